// File: doc/BRIEF.md
# Dual-Region Parallel Memory Host Controller

This block sits between a synchronous request source and an asynchronous byte-wide memory device that holds two independent regions: a fast region (flash-like, 512 KB in eight 64 KB sectors) and a slow region (EEPROM-like) that runs internal write cycles. Each region has its own active-low select. The two regions share the output strobe, the write strobe, the address pins and the data pins. An open-drain ready line, pulled up on the board, goes low only while the slow region is busy with an internal write.

Requests arrive on a valid/ready channel. Each request carries a one-hot region select, a read/write flag, an address and write data. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends only on the controller state and on the request fields, never on `req_valid`, so a source may present a request and wait. A source under back-pressure must hold its request fields stable until the handshake completes.

The controller turns each accepted request into a strobe sequence: one setup cycle, a strobe of `STROBE_CYC` cycles, and a hold cycle for writes. It keeps the two selects mutually exclusive and leaves a programmable idle gap when it changes region. It drives the data pins only for writes, with one turnaround cycle after a read. It also holds back slow-region traffic while the synchronised ready line shows busy. Each read completes with a single-cycle response pulse. Each fast-region access also updates a sector index output.

Top module: `dmem_host_ctrl`

## Requirements
- R1: `mem_ce_n` is never `2'b00`. Bit 0 selects the fast region and bit 1 selects the slow region, both active low.
- R2: When an access targets a region other than the previous one, both selects are high for at least `GAP_CYC` consecutive cycles before the new select goes low. Back-to-back accesses to the same region need no such gap.
- R3: A write accepted in cycle n produces the following sequence:
  - cycle n+1: select low, address valid, data driven, `mem_we_n` high;
  - the next `STROBE_CYC` cycles: `mem_we_n` low, with the address and data unchanged;
  - one more cycle: `mem_we_n` high, select still low, data still driven;
  - after that: both selects high.
- R4: A read accepted in cycle n produces the following sequence:
  - cycle n+1: setup, with the select low and both strobes high;
  - the next `STROBE_CYC` cycles: `mem_oe_n` low while `mem_we_n` stays high;
  - the following cycle: both selects high and `rsp_valid` high for exactly one cycle. `rsp_rdata` holds the byte present on `mem_dq_in` in the last strobe cycle.
- R5: `mem_dq_oe` is high only during write sequences, and never while `mem_oe_n` is low or both selects are high.
- R6: `mem_rb` passes through `SYNC_STAGES` flip-flops. A slow-region request (`req_region = 2'b10`) sees `req_ready` low while the synchronised line is 0.
- R7: Fast-region requests (`req_region = 2'b01`) are accepted regardless of `mem_rb`.
- R8: After a fast-region request is accepted, `flash_sector` shows `req_addr[ADDR_W-1:ADDR_W-3]` from the following cycle on. It keeps that value until the next fast-region acceptance.
- R9: A `req_region` that is not one-hot (`2'b00` or `2'b11`) keeps `req_ready` low and leaves the memory pins idle.
- R10: A write is not accepted in the first idle cycle after a read, so `mem_dq_oe` never rises within two cycles of `mem_oe_n` being low.
- R11: During and straight after reset, the following hold:
  - both selects, `mem_oe_n` and `mem_we_n` are high;
  - `mem_dq_oe` is low;
  - `rsp_valid` is low;
  - `flash_sector` is 0.
- R12: `req_ready` is high only while no access is in progress. Every accepted request produces exactly one strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | One-hot region select: 01 fast, 10 slow |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | DATA_W | Read data |
| flash_sector | output | 3 | Sector index of the latest fast-region access |
| mem_ce_n | output | 2 | Active-low region selects |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | Address pins |
| mem_dq_out | output | DATA_W | Data to the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Data from the pad receiver |
| mem_rb | input | 1 | Ready/busy of the slow region, 0 = busy |

## Verification
The bench builds the controller with the following parameters:

| Parameter | Value |
|---|---|
| `ADDR_W` | 19 |
| `STROBE_CYC` | 2 |
| `GAP_CYC` | 3 |
| `SYNC_STAGES` | 2 |

With these values, every region switch stalls visibly for a few cycles, and the turnaround stall falls inside the gap window only when the region changes. A same-region read followed by a write therefore isolates the turnaround rule. The full 19-bit address puts all eight sector codes within reach. The two-stage synchroniser makes the busy-to-ready latency long enough that a held slow request can be seen stalling after `mem_rb` has already risen.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
  localparam int SECT_W = 3;
  localparam logic [1:0] SEL_FAST = 2'b01;
  localparam logic [1:0] SEL_SLOW = 2'b10;
  localparam logic [1:0] CE_NONE  = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/memctl_rb_sync.sv
module memctl_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_ready
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= rb_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], rb_async};
      end
    end
  endgenerate

  assign rb_ready = sh[STAGES-1];
endmodule

// File: rtl/memctl_admit.sv
module memctl_admit #(
  parameter int GAP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_region,
  input  logic       rb_ready,
  output logic       req_ready,
  output logic       accept
);
  import memctl_pkg::*;

  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(GAP_CYC);
  localparam logic [CW-1:0] CNT_NEED = CW'(GAP_CYC - 1);

  logic [CW-1:0] idle_cnt;
  logic          have_last, last_slow, last_read;
  logic          legal, tgt_slow, busy_blk, gap_ok, turn_blk;

  assign legal    = (req_region == SEL_FAST) || (req_region == SEL_SLOW);
  assign tgt_slow = req_region[1];
  assign busy_blk = tgt_slow && !rb_ready;
  assign gap_ok   = !have_last || (last_slow == tgt_slow) || (idle_cnt >= CNT_NEED);
  assign turn_blk = req_write && last_read && (idle_cnt == '0);

  assign req_ready = idle && legal && !busy_blk && gap_ok && !turn_blk;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      have_last <= 1'b0;
      last_slow <= 1'b0;
      last_read <= 1'b0;
    end else begin
      if (!idle)                   idle_cnt <= '0;
      else if (idle_cnt < CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
      if (accept) begin
        have_last <= 1'b1;
        last_slow <= tgt_slow;
        last_read <= !req_write;
      end
    end
  end
endmodule

// File: rtl/memctl_strobe.sv
module memctl_strobe #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [1:0]        req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              idle,
  output logic [1:0]        mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  import memctl_pkg::*;

  localparam int SCW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [SCW-1:0] S_LAST = SCW'(STROBE_CYC - 1);

  phase_e         ph;
  logic [SCW-1:0] scnt;
  logic           wr;

  assign idle = (ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      scnt       <= '0;
      wr         <= 1'b0;
      mem_ce_n   <= CE_NONE;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (ph)
        PH_IDLE: if (accept) begin
          ph         <= PH_SETUP;
          wr         <= req_write;
          mem_addr   <= req_addr;
          mem_ce_n   <= req_region[1] ? 2'b01 : 2'b10;
          mem_dq_out <= req_wdata;
          mem_dq_oe  <= req_write;
        end
        PH_SETUP: begin
          ph   <= PH_STROBE;
          scnt <= '0;
          if (wr) mem_we_n <= 1'b0;
          else    mem_oe_n <= 1'b0;
        end
        PH_STROBE: begin
          if (scnt == S_LAST) begin
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            if (wr) begin
              ph <= PH_HOLD;
            end else begin
              ph        <= PH_IDLE;
              mem_ce_n  <= CE_NONE;
              rsp_valid <= 1'b1;
              rsp_rdata <= mem_dq_in;
            end
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        PH_HOLD: begin
          ph        <= PH_IDLE;
          mem_ce_n  <= CE_NONE;
          mem_dq_oe <= 1'b0;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmem_host_ctrl.sv
module dmem_host_ctrl #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int STROBE_CYC  = 3,
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [2:0]        flash_sector,
  output logic [1:0]        mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_rb
);
  import memctl_pkg::*;

  logic rb_ready, idle, accept;

  memctl_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rb_async(mem_rb), .rb_ready(rb_ready)
  );

  memctl_admit #(.GAP_CYC(GAP_CYC)) u_admit (
    .clk(clk), .rst_n(rst_n), .idle(idle), .req_valid(req_valid),
    .req_write(req_write), .req_region(req_region), .rb_ready(rb_ready),
    .req_ready(req_ready), .accept(accept)
  );

  memctl_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_dq_in(mem_dq_in), .idle(idle), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   flash_sector <= '0;
    else if (accept && req_region == SEL_FAST)    flash_sector <= req_addr[ADDR_W-1 -: SECT_W];
  end
endmodule

// File: rtl/memctl_chk.sv
module memctl_chk #(
  parameter int ADDR_W  = 19,
  parameter int GAP_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_region,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        flash_sector,
  input logic [1:0]        mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_dq_out,
  input logic              mem_dq_oe,
  input logic              rb_ready
);
  int unsigned hi_run;
  logic        seen_low, last_low_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run        <= 0;
      seen_low      <= 1'b0;
      last_low_slow <= 1'b0;
    end else begin
      if (mem_ce_n == 2'b11) begin
        if (hi_run < GAP_CYC) hi_run <= hi_run + 1;
      end else begin
        hi_run <= 0;
      end
      if (!mem_ce_n[0]) begin seen_low <= 1'b1; last_low_slow <= 1'b0; end
      if (!mem_ce_n[1]) begin seen_low <= 1'b1; last_low_slow <= 1'b1; end
    end
  end

  // R1
  ce_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_ce_n != 2'b00);

  // R2
  switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_low && ((!mem_ce_n[0] && $past(mem_ce_n[0]) && last_low_slow) ||
                  (!mem_ce_n[1] && $past(mem_ce_n[1]) && !last_low_slow)))
    |-> hi_run >= GAP_CYC);

  // R3
  we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $stable(mem_addr) && mem_dq_oe && mem_ce_n != 2'b11);

  // R3
  we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe && $past(mem_dq_oe) && $stable(mem_dq_out));

  // R4
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n && $countones(~mem_ce_n) == 1);

  // R5
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n && mem_ce_n != 2'b11);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_region == 2'b10) |-> rb_ready);

  // R8
  sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_region == 2'b01) |=> flash_sector == $past(req_addr[ADDR_W-1 -: 3]));

  // R9
  region_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $countones(req_region) == 1);

  // R10
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> mem_oe_n && $past(mem_oe_n) && $past(mem_oe_n, 2));

  // R12
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n == 2'b11);
endmodule

bind dmem_host_ctrl memctl_chk #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_region(req_region), .req_addr(req_addr), .flash_sector(flash_sector),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_dq_out(mem_dq_out[7:0]), .mem_dq_oe(mem_dq_oe),
  .rb_ready(rb_ready)
);

// File: tb/test_dmem_host_ctrl.sv
`timescale 1ns/1ps
module test_dmem_host_ctrl;
  localparam int AW = 19, DW = 8, SW = 2, GAP = 3, SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [1:0] req_region = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [2:0] flash_sector;
  logic [1:0] mem_ce_n;
  logic [AW-1:0] mem_addr;
  logic mem_rb = 1'b1;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] dev_byte(input logic [AW-1:0] a, input logic slow);
    return a[7:0] ^ a[15:8] ^ (slow ? 8'hC3 : 8'h3C);
  endfunction

  assign mem_dq_in = (!mem_oe_n && mem_ce_n != 2'b11) ? dev_byte(mem_addr, !mem_ce_n[1]) : 8'h00;

  dmem_host_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(SW), .GAP_CYC(GAP), .SYNC_STAGES(SYNC))
  i_dmem_host_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_region(req_region), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .flash_sector(flash_sector), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_rb(mem_rb)
  );

  typedef struct packed {
    logic [1:0]    ce;
    logic          oe, we, doe, rv, has_addr;
    logic [AW-1:0] addr;
    logic [7:0]    dout, rdata;
  } exp_t;

  localparam exp_t IDLE_E = '{ce: 2'b11, oe: 1'b1, we: 1'b1, doe: 1'b0, rv: 1'b0,
                              has_addr: 1'b0, addr: '0, dout: '0, rdata: '0};

  exp_t q[$];
  exp_t cur;
  int nchk = 0, nfail = 0, hi_cnt = 1;
  bit have_last = 0, last_slow = 0, last_read = 0, done = 0;
  logic rb_cur = 1'b1, rb_d1 = 1'b0, rb_d2 = 1'b0;
  logic [2:0] exp_sector = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic tick(input bit v, input bit w, input logic [1:0] rg,
                      input logic [AW-1:0] a, input logic [7:0] wd, input logic rb,
                      output bit acc);
    bit legal, slow, busy, gapok, turn, eready;
    string tag;
    exp_t e;
    @(negedge clk);
    rb_d2 = rb_d1; rb_d1 = rb_cur;
    cur = (q.size() != 0) ? q.pop_front() : IDLE_E;
    if (cur.ce == 2'b11) hi_cnt++; else hi_cnt = 0;
    req_valid = v; req_write = w; req_region = rg; req_addr = a; req_wdata = wd;
    mem_rb = rb; rb_cur = rb;
    #1;
    legal  = (rg == 2'b01) || (rg == 2'b10);
    slow   = rg[1];
    busy   = slow && !rb_d2;
    gapok  = !have_last || (last_slow == slow) || (hi_cnt >= GAP);
    turn   = w && last_read && (hi_cnt == 1);
    eready = (cur.ce == 2'b11) && (q.size() == 0) && legal && !busy && gapok && !turn;
    if (!legal) tag = "R9";
    else if (busy) tag = "R6";
    else if (!slow && !rb_d2) tag = "R7";
    else if (turn) tag = "R10";
    else if (!gapok) tag = "R2";
    else tag = "R12";
    check(mem_ce_n != 2'b00, "R1", "both selects low", 32'(mem_ce_n), 32'h3);
    check(mem_ce_n == cur.ce, "R2", "mem_ce_n", 32'(mem_ce_n), 32'(cur.ce));
    check(mem_oe_n == cur.oe, "R4", "mem_oe_n", 32'(mem_oe_n), 32'(cur.oe));
    check(mem_we_n == cur.we, "R3", "mem_we_n", 32'(mem_we_n), 32'(cur.we));
    check(mem_dq_oe == cur.doe, "R5", "mem_dq_oe", 32'(mem_dq_oe), 32'(cur.doe));
    if (cur.has_addr) check(mem_addr == cur.addr, "R3", "mem_addr", 32'(mem_addr), 32'(cur.addr));
    if (cur.doe) check(mem_dq_out == cur.dout, "R3", "mem_dq_out", 32'(mem_dq_out), 32'(cur.dout));
    check(rsp_valid == cur.rv, "R4", "rsp_valid", 32'(rsp_valid), 32'(cur.rv));
    if (cur.rv) check(rsp_rdata == cur.rdata, "R4", "rsp_rdata", 32'(rsp_rdata), 32'(cur.rdata));
    check(flash_sector == exp_sector, "R8", "flash_sector", 32'(flash_sector), 32'(exp_sector));
    check(req_ready == eready, tag, "req_ready", 32'(req_ready), 32'(eready));
    acc = v && eready;
    if (acc) begin
      e = '{ce: slow ? 2'b01 : 2'b10, oe: 1'b1, we: 1'b1, doe: w, rv: 1'b0,
            has_addr: 1'b1, addr: a, dout: wd, rdata: '0};
      q.push_back(e);
      e.oe = w; e.we = !w;
      for (int k = 0; k < SW; k++) q.push_back(e);
      if (w) begin
        e.oe = 1'b1; e.we = 1'b1;
        q.push_back(e);
      end else begin
        e = IDLE_E; e.rv = 1'b1; e.rdata = dev_byte(a, slow);
        q.push_back(e);
      end
      have_last = 1; last_slow = slow; last_read = !w;
      if (!slow) exp_sector = a[AW-1 -: 3];
    end
  endtask

  task automatic issue(input bit w, input logic [1:0] rg, input logic [AW-1:0] a,
                       input logic [7:0] wd, input logic rb, input int maxw);
    bit acc = 0;
    for (int k = 0; k < maxw && !acc; k++) tick(1'b1, w, rg, a, wd, rb, acc);
  endtask

  task automatic idle_cycles(input int n, input logic rb);
    bit acc;
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, 2'b00, '0, '0, rb, acc);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nfail++;
      $display("FAIL R12 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit acc;
    int lf;
    repeat (3) @(negedge clk);
    // R11: state while reset is held
    check(mem_ce_n == 2'b11, "R11", "reset mem_ce_n", 32'(mem_ce_n), 32'h3);
    check(mem_oe_n && mem_we_n, "R11", "reset strobes", 32'({mem_oe_n, mem_we_n}), 32'h3);
    check(!mem_dq_oe, "R11", "reset mem_dq_oe", 32'(mem_dq_oe), 32'h0);
    check(!rsp_valid && flash_sector == 3'd0, "R11", "reset rsp/sector",
          32'({rsp_valid, flash_sector}), 32'h0);
    rst_n = 1'b1;
    idle_cycles(3, 1'b1);
    // R4 R8: fast reads, same region back to back
    issue(0, 2'b01, 19'h1_2345, 8'h00, 1'b1, 20);
    issue(0, 2'b01, 19'h7_00FF, 8'h00, 1'b1, 20);
    // R10: write right after read in the same region
    issue(1, 2'b01, 19'h3_0010, 8'hA5, 1'b1, 20);
    // R2: switch to slow region and back
    issue(1, 2'b10, 19'h0_0020, 8'h5A, 1'b1, 20);
    issue(0, 2'b01, 19'h5_4321, 8'h00, 1'b1, 20);
    issue(0, 2'b10, 19'h0_1111, 8'h00, 1'b1, 20);
    idle_cycles(4, 1'b1);
    // R9: illegal region selects held
    for (int k = 0; k < 6; k++) tick(1'b1, 1'b0, 2'b11, 19'h1_0000, '0, 1'b1, acc);
    for (int k = 0; k < 4; k++) tick(1'b1, 1'b1, 2'b00, 19'h2_0000, 8'h11, 1'b1, acc);
    // R6: slow request held while busy
    for (int k = 0; k < 8; k++) tick(1'b1, 1'b0, 2'b10, 19'h0_0042, '0, 1'b0, acc);
    // R7: fast traffic while busy
    issue(0, 2'b01, 19'h6_0A0A, 8'h00, 1'b0, 20);
    issue(1, 2'b01, 19'h2_0B0B, 8'h3C, 1'b0, 20);
    // R6: slow proceeds after synchronised ready
    issue(0, 2'b10, 19'h0_0042, 8'h00, 1'b1, 20);
    // mixed traffic
    lf = 32'h1D2C;
    for (int i = 0; i < 60; i++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7FFF_FFFF;
      issue(lf[4], lf[5] ? 2'b10 : 2'b01, AW'(lf >> 8), 8'(lf >> 3),
            (i % 5) != 0, 12);
    end
    idle_cycles(10, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule